// File: doc/BRIEF.md
# Interrupt-capable GPIO port controller

This block manages a port of general-purpose pins, 16 by default. Each pin can be an input or an output. Software reaches it through a plain register port of 16-bit words. Output pins are driven from an output register. That register can be written whole, or changed bit by bit through separate set and clear strobes, so no read-modify-write sequence is needed. Input pins pass through a two-flop synchronizer before any logic uses them.

Every pin can also raise an interrupt. A pin is either level-sensitive, with a selectable active level, or edge-sensitive, with independent rising and falling enables. Events are held in a pending register. The pending bits reach the single interrupt line only where the pin's mask bit is 0 and its enable bit is 1.

The register port is a plain request interface, not a stream. A request is accepted in any cycle in which `req_valid` is high; there is no back-pressure. A read answers exactly one cycle later with `rsp_valid` high for one cycle. A write produces no response.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, direction, output, level select, polarity, both edge enables, the interrupt enable and pending all read 0, the mask register at 0x28 reads 0xFFFF, and `irq` is 0.
- R2: Register 0x00 holds the direction: bit value 1 makes the pin an output, and `pin_oe` equals this register. `pin_out` equals the output register at 0x20, which software can write whole and read back.
- R3: A write to 0x18 sets the output bits written as 1. A write to 0x1C clears the output bits written as 1. Bits written as 0 keep their value. Both addresses read as 0.
- R4: Register 0x14 is read-only and returns `pin_in` after a two-flop synchronizer, so a pin change shows up in reads issued two or more cycles later.
- R5: A pin whose bit in 0x04 is 1 is level-sensitive. Its bit in 0x08 picks the active level (1 = high, 0 = low). While the synchronized pin is at that level, its pending bit is set one cycle later, and a clear does not remove it.
- R6: A pin whose bit in 0x04 is 0 is edge-sensitive. A 0-to-1 change of the synchronized value sets pending if the pin's bit in 0x0C is 1. A 1-to-0 change sets pending if its bit in 0x10 is 1. With both bits set, either edge triggers.
- R7: A pending bit stays set until a 1 is written to that bit of 0x34. If a new event for the pin arrives in the same cycle as that clear, the bit stays set.
- R8: 0x24 returns the raw pending bits. 0x30 returns pending AND NOT mask (0x28) AND enable (0x2C).
- R9: `irq` is 1 exactly when any bit of the masked status is 1.
- R10: A read returns its data on `rsp_rdata` with `rsp_valid` high in the following cycle only. Writes give no response. Unmapped addresses read 0, and writes to them or to read-only registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address of the register |
| req_wdata | input | N_PINS | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read) |
| rsp_rdata | output | N_PINS | Read data |
| pin_in | input | N_PINS | Asynchronous pin inputs |
| pin_out | output | N_PINS | Output levels |
| pin_oe | output | N_PINS | Output enables (1 = output) |
| irq | output | 1 | Combined interrupt |

## Verification
The bench targets five corner cases:
- **Clear on the same edge as a new event.** A design that lets the clear win would lose an interrupt.
- **Level pin cleared while its level is still active.** A design that treats level pins like edges would drop `irq` falsely.
- **Falling edge on a pin armed only for rising edges, and the reverse.** A design that fails to keep the enables apart would report spurious pending.
- **Mask and enable gating in both directions.** A design that used one gate alone would raise `irq` for a masked pin.
- **Set/clear strobes that must leave untouched bits alone.** A design that gets this wrong would corrupt neighbouring outputs.

A behavioural model tracks the synchronizer delay cycle by cycle. An off-by-one in the input path therefore shows up as a mismatch in read data or in `irq`.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_DIR  = 8'h00;
  localparam logic [ADDR_W-1:0] A_LSEL = 8'h04;
  localparam logic [ADDR_W-1:0] A_POL  = 8'h08;
  localparam logic [ADDR_W-1:0] A_RISE = 8'h0C;
  localparam logic [ADDR_W-1:0] A_FALL = 8'h10;
  localparam logic [ADDR_W-1:0] A_IN   = 8'h14;
  localparam logic [ADDR_W-1:0] A_SET  = 8'h18;
  localparam logic [ADDR_W-1:0] A_CLR  = 8'h1C;
  localparam logic [ADDR_W-1:0] A_OUT  = 8'h20;
  localparam logic [ADDR_W-1:0] A_RAW  = 8'h24;
  localparam logic [ADDR_W-1:0] A_MASK = 8'h28;
  localparam logic [ADDR_W-1:0] A_EN   = 8'h2C;
  localparam logic [ADDR_W-1:0] A_STAT = 8'h30;
  localparam logic [ADDR_W-1:0] A_ICLR = 8'h34;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int N_PINS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] cur,
  output logic [N_PINS-1:0] prev
);
  logic [N_PINS-1:0] stage1;
  logic [N_PINS-1:0] stage2;
  logic [N_PINS-1:0] stage3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
      stage3 <= '0;
    end else begin
      stage1 <= pin_in;
      stage2 <= stage1;
      stage3 <= stage2;
    end
  end

  assign cur  = stage2;
  assign prev = stage3;

  // Cycles since reset release, saturating; used only by the latency check.
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= '0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  p_sync_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (cur == $past(pin_in, 2)));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int N_PINS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] cur,
  input  logic [N_PINS-1:0] prev,
  input  logic [N_PINS-1:0] lvl_sel,
  input  logic [N_PINS-1:0] pol,
  input  logic [N_PINS-1:0] rise_en,
  input  logic [N_PINS-1:0] fall_en,
  input  logic [N_PINS-1:0] clr_bits,
  output logic [N_PINS-1:0] pend
);
  logic [N_PINS-1:0] edge_hit;
  logic [N_PINS-1:0] lvl_hit;

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    logic went_up;
    logic went_down;
    assign went_up     = cur[i] & ~prev[i];
    assign went_down   = ~cur[i] & prev[i];
    assign edge_hit[i] = ~lvl_sel[i] & ((went_up & rise_en[i]) | (went_down & fall_en[i]));
    assign lvl_hit[i]  = lvl_sel[i] & ~(cur[i] ^ pol[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_bits) | edge_hit | lvl_hit;
  end

  // R7: a bit that is not cleared never drops
  p_pend_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(pend & ~clr_bits)) == $past(pend & ~clr_bits)));
  // R7/R6: an edge event wins over a clear in the same cycle
  p_edge_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(edge_hit)) == $past(edge_hit)));
  // R5: an active level keeps the bit pending
  p_level_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(lvl_hit)) == $past(lvl_hit)));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int N_PINS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [N_PINS-1:0] req_wdata,
  input  logic [N_PINS-1:0] in_sync,
  input  logic [N_PINS-1:0] pend,
  output logic [N_PINS-1:0] dir_q,
  output logic [N_PINS-1:0] lsel_q,
  output logic [N_PINS-1:0] pol_q,
  output logic [N_PINS-1:0] rise_q,
  output logic [N_PINS-1:0] fall_q,
  output logic [N_PINS-1:0] out_q,
  output logic [N_PINS-1:0] clr_bits,
  output logic [N_PINS-1:0] masked,
  output logic              rsp_valid,
  output logic [N_PINS-1:0] rsp_rdata
);
  logic [N_PINS-1:0] mask_q;
  logic [N_PINS-1:0] en_q;
  logic [N_PINS-1:0] rd_mux;
  logic              wr;
  logic              rd;

  assign wr = req_valid & req_write;
  assign rd = req_valid & ~req_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      lsel_q <= '0;
      pol_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      out_q  <= '0;
      mask_q <= '1;
      en_q   <= '0;
    end else if (wr) begin
      case (req_addr)
        A_DIR:   dir_q  <= req_wdata;
        A_LSEL:  lsel_q <= req_wdata;
        A_POL:   pol_q  <= req_wdata;
        A_RISE:  rise_q <= req_wdata;
        A_FALL:  fall_q <= req_wdata;
        A_SET:   out_q  <= out_q | req_wdata;
        A_CLR:   out_q  <= out_q & ~req_wdata;
        A_OUT:   out_q  <= req_wdata;
        A_MASK:  mask_q <= req_wdata;
        A_EN:    en_q   <= req_wdata;
        default: ;
      endcase
    end
  end

  assign clr_bits = (wr && req_addr == A_ICLR) ? req_wdata : '0;
  assign masked   = pend & ~mask_q & en_q;

  always_comb begin
    case (req_addr)
      A_DIR:   rd_mux = dir_q;
      A_LSEL:  rd_mux = lsel_q;
      A_POL:   rd_mux = pol_q;
      A_RISE:  rd_mux = rise_q;
      A_FALL:  rd_mux = fall_q;
      A_IN:    rd_mux = in_sync;
      A_OUT:   rd_mux = out_q;
      A_RAW:   rd_mux = pend;
      A_MASK:  rd_mux = mask_q;
      A_EN:    rd_mux = en_q;
      A_STAT:  rd_mux = masked;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      rsp_rdata <= rd ? rd_mux : '0;
    end
  end

  p_rsp_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));
  p_set_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_addr == A_SET) |=> ((out_q & $past(req_wdata)) == $past(req_wdata)));
  p_clr_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_addr == A_CLR) |=> ((out_q & $past(req_wdata)) == '0));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int N_PINS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [N_PINS-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [N_PINS-1:0] rsp_rdata,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_oe,
  output logic              irq
);
  logic [N_PINS-1:0] cur, prev, pend, masked, clr_bits;
  logic [N_PINS-1:0] dir_q, lsel_q, pol_q, rise_q, fall_q, out_q;

  gpio_sync #(.N_PINS(N_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cur(cur), .prev(prev)
  );

  gpio_irq_detect #(.N_PINS(N_PINS)) u_detect (
    .clk(clk), .rst_n(rst_n), .cur(cur), .prev(prev),
    .lvl_sel(lsel_q), .pol(pol_q), .rise_en(rise_q), .fall_en(fall_q),
    .clr_bits(clr_bits), .pend(pend)
  );

  gpio_regs #(.N_PINS(N_PINS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .in_sync(cur), .pend(pend),
    .dir_q(dir_q), .lsel_q(lsel_q), .pol_q(pol_q), .rise_q(rise_q),
    .fall_q(fall_q), .out_q(out_q), .clr_bits(clr_bits), .masked(masked),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq     = |masked;

  // R9: irq never asserted without a pending bit behind it
  p_irq_needs_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend != '0));
endmodule

// File: tb/sim_gpio_irq_port.sv
module sim_gpio_irq_port;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [15:0] req_wdata = '0, pin_in = '0;
  logic        rsp_valid, irq;
  logic [15:0] rsp_rdata, pin_out, pin_oe;

  gpio_irq_port u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  int checks = 0, errors = 0;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [15:0] m_dir, m_lsel, m_pol, m_rise, m_fall, m_out, m_mask, m_en, m_pend;
  logic [15:0] h1, h2, h3, m_rd;
  logic        m_rv;

  function automatic logic [15:0] m_read(logic [7:0] a);
    case (a)
      8'h00: return m_dir;   8'h04: return m_lsel;  8'h08: return m_pol;
      8'h0C: return m_rise;  8'h10: return m_fall;  8'h14: return h2;
      8'h20: return m_out;   8'h24: return m_pend;  8'h28: return m_mask;
      8'h2C: return m_en;    8'h30: return m_pend & ~m_mask & m_en;
      default: return 16'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = 0; m_lsel = 0; m_pol = 0; m_rise = 0; m_fall = 0; m_out = 0;
      m_mask = 16'hFFFF; m_en = 0; m_pend = 0; h1 = 0; h2 = 0; h3 = 0;
      m_rv = 0; m_rd = 0;
    end else begin
      logic [15:0] np;
      m_rv = req_valid && !req_write;
      m_rd = m_rv ? m_read(req_addr) : 16'h0;
      for (int i = 0; i < 16; i++) begin
        bit up, dn, ev, lv, cl;
        up = h2[i] && !h3[i];
        dn = !h2[i] && h3[i];
        ev = !m_lsel[i] && ((up && m_rise[i]) || (dn && m_fall[i]));
        lv = m_lsel[i] && (h2[i] == m_pol[i]);
        cl = req_valid && req_write && req_addr == 8'h34 && req_wdata[i];
        np[i] = (m_pend[i] && !cl) || ev || lv;
      end
      m_pend = np;
      if (req_valid && req_write) begin
        case (req_addr)
          8'h00: m_dir = req_wdata;  8'h04: m_lsel = req_wdata;
          8'h08: m_pol = req_wdata;  8'h0C: m_rise = req_wdata;
          8'h10: m_fall = req_wdata; 8'h18: m_out = m_out | req_wdata;
          8'h1C: m_out = m_out & ~req_wdata; 8'h20: m_out = req_wdata;
          8'h28: m_mask = req_wdata; 8'h2C: m_en = req_wdata;
          default: ;
        endcase
      end
      h3 = h2; h2 = h1; h1 = pin_in;
    end
  end

  // Every-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    chk("R2 pin_oe", pin_oe, m_dir);
    chk("R3 pin_out", pin_out, m_out);
    chk("R9 irq", {15'b0, irq}, {15'b0, |(m_pend & ~m_mask & m_en)});
    chk("R10 rsp_valid", {15'b0, rsp_valid}, {15'b0, m_rv});
    if (m_rv) chk("R10 rsp_rdata (R4 R5 R6 R7 R8)", rsp_rdata, m_rd);
  end

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    d = rsp_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    idle(3);
    rst_n = 1;
    idle(1);
    // R1 reset state
    chk("R1 pin_oe", pin_oe, 16'h0);
    chk("R1 pin_out", pin_out, 16'h0);
    chk("R1 irq", {15'b0, irq}, 16'h0);
    rd(8'h28, d); chk("R1 mask", d, 16'hFFFF);
    rd(8'h2C, d); chk("R1 enable", d, 16'h0);
    rd(8'h24, d); chk("R1 raw", d, 16'h0);
    // R2 / R3 outputs
    wr(8'h00, 16'h00FF);
    wr(8'h18, 16'h0F0F);
    chk("R3 set", pin_out, 16'h0F0F);
    chk("R2 oe", pin_oe, 16'h00FF);
    wr(8'h1C, 16'h0003);
    chk("R3 clear keeps others", pin_out, 16'h0F0C);
    wr(8'h20, 16'h1234);
    rd(8'h20, d); chk("R2 out readback", d, 16'h1234);
    rd(8'h18, d); chk("R3 set reads 0", d, 16'h0);
    // R4 synchronized input
    pin_in = 16'hA5A5;
    idle(3);
    rd(8'h14, d); chk("R4 input", d, 16'hA5A5);
    // R10 unmapped / read-only write ignored
    wr(8'h14, 16'hFFFF);
    rd(8'h14, d); chk("R10 ro input", d, 16'hA5A5);
    rd(8'h3C, d); chk("R10 unmapped", d, 16'h0);
    // R5 level high on pin 0
    wr(8'h28, 16'hFFFE); wr(8'h2C, 16'h0001);
    wr(8'h08, 16'h0001); wr(8'h04, 16'h0001);
    idle(4);
    chk("R5 level irq", {15'b0, irq}, 16'h1);
    wr(8'h34, 16'h0001); idle(2);
    chk("R5 level survives clear", {15'b0, irq}, 16'h1);
    pin_in = 16'hA5A4; idle(4);
    wr(8'h34, 16'h0001); idle(2);
    chk("R5 level gone", {15'b0, irq}, 16'h0);
    // R6 edges on pin 1
    wr(8'h04, 16'h0000); wr(8'h28, 16'hFFFC); wr(8'h2C, 16'h0003);
    wr(8'h0C, 16'h0002); wr(8'h34, 16'hFFFF);
    pin_in = 16'hA5A6; idle(4);
    rd(8'h24, d); chk("R6 rising", d, 16'h0002);
    rd(8'h30, d); chk("R8 status", d, 16'h0002);
    wr(8'h28, 16'hFFFE);
    rd(8'h30, d); chk("R8 masked off", d, 16'h0000);
    chk("R9 irq masked", {15'b0, irq}, 16'h0);
    wr(8'h34, 16'h0002);
    pin_in = 16'hA5A4; idle(4);
    rd(8'h24, d); chk("R6 fall not armed", d, 16'h0000);
    wr(8'h10, 16'h0002);
    pin_in = 16'hA5A6; idle(4); wr(8'h34, 16'h0002);
    pin_in = 16'hA5A4; idle(4);
    rd(8'h24, d); chk("R6 both edges fall", d, 16'h0002);
    rd(8'h24, d); chk("R7 sticky", d, 16'h0002);
    // R7 clear collisions and mixed traffic, checked against the model
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      if ($urandom_range(0, 2) == 0) pin_in = pin_in ^ (16'h1 << $urandom_range(0, 15));
      req_valid = $urandom_range(0, 1);
      req_write = $urandom_range(0, 1);
      req_addr  = 8'($urandom_range(0, 15) * 4);
      req_wdata = 16'($urandom);
      if (n % 7 == 0) begin req_write = 1; req_addr = 8'h34; end
    end
    @(negedge clk); req_valid = 0;
    idle(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule